// File: doc/BRIEF.md
# Length-Prefixed Multi-Packet Transmit Tracker

This block follows a transmit buffer that carries several packets stored back to back. Every packet opens with a two-byte length prefix. The prefix is big-endian and holds the number of bytes that follow it, so a packet takes length + 2 bytes. Software marks only the first packet: a packet-start flag given with the buffer says that byte 0 opens a prefix. From then on the block finds each following packet boundary by reading the prefixes itself.

A buffer begins with a one-cycle `start_i` pulse that carries the packet-start flag and the buffer depth in bytes. The bytes read from the buffer then arrive in order, each qualified by `in_valid_i`. Each byte comes out one cycle later, tagged with start-of-packet and end-of-packet markers. A buffer-done pulse goes with the byte at index depth-1.

The depth must hold a whole number of complete packets. A packet that would run past the buffer end, or a length above 2046, raises a sticky format error. From that point no packet markers are issued. Address generation and ping/pong selection belong to the surrounding logic.

Top module: `mpt_tx_tracker`

## Requirements
- R1: After reset, all outputs are low: `out_valid_o`, `out_byte_o`, `out_sop_o`, `out_eop_o`, `buf_done_o` and `fmt_err_o`.
- R2: An active buffer accepts a byte in each cycle with `in_valid_i` high and `start_i` low. Each accepted byte appears on `out_byte_o` with `out_valid_o` high exactly one cycle later, in arrival order.
- R3: `out_sop_o` marks the first prefix byte of each packet. The first packet starts at byte 0. The prefix is big-endian: the first byte is bits 15:8. The prefix value L counts the bytes after the prefix, so the next packet starts L+2 bytes later.
- R4: `out_eop_o` marks the last byte of each packet. When L is 0, that is the second prefix byte.
- R5: `buf_done_o` pulses together with the output of the byte at index depth-1. The buffer then goes idle, and further bytes produce no output until the next `start_i`.
- R6: If `pkt_start_i` is low, or `depth_i` is 0, at `start_i`, then `fmt_err_o` is high in the next cycle and no byte of that buffer is emitted.
- R7: A prefix value above 2046 raises `fmt_err_o` in the cycle that outputs its second prefix byte. No `out_sop_o` or `out_eop_o` is issued from that byte on, but bytes and `buf_done_o` still flow.
- R8: A packet that does not fit in the rest of the buffer raises `fmt_err_o`, with the same muting as R7. This covers two cases: a prefix whose last packet byte would fall at an index above depth-1, and a first prefix byte that falls on index depth-1.
- R9: `fmt_err_o` stays high until the next `start_i`. A `start_i` with a valid setup clears it in the following cycle.
- R10: `start_i` restarts tracking at byte 0 even in the middle of a buffer. A byte presented in the same cycle as `start_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that opens a buffer |
| pkt_start_i | input | 1 | Byte 0 of the buffer opens a length prefix |
| depth_i | input | DEPTH_W | Buffer depth in bytes, sampled at `start_i` |
| in_valid_i | input | 1 | Input byte qualifier |
| in_byte_i | input | 8 | Byte read from the buffer |
| out_valid_o | output | 1 | Output byte qualifier |
| out_byte_o | output | 8 | Forwarded byte |
| out_sop_o | output | 1 | First byte of a packet |
| out_eop_o | output | 1 | Last byte of a packet |
| buf_done_o | output | 1 | Last byte of the buffer |
| fmt_err_o | output | 1 | Sticky format error |

## Verification
Every per-byte result is due one register stage after the byte is accepted. This covers the forwarded byte, its sop/eop tags, the done pulse and the error flag raised by that byte. An error from a bad start is due in the cycle after `start_i`. The bench drives inputs on the falling edge and records outputs on the following falling edge. Each recorded byte is compared in order against tags that bench functions derive from the requirements. The error flag is compared per byte, so its due cycle is checked exactly, and the number of emitted bytes checks both the dropped start-cycle byte and the idle state after done.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  typedef enum logic [1:0] {
    PH_LEN_HI = 2'd0,
    PH_LEN_LO = 2'd1,
    PH_BODY   = 2'd2
  } phase_e;

  localparam int unsigned PREFIX_BYTES = 2;
  localparam int unsigned MAX_PKT_BYTES = 2048;
  localparam int unsigned MAX_LEN = MAX_PKT_BYTES - PREFIX_BYTES;
endpackage

// File: rtl/mpt_pos_count.sv
module mpt_pos_count #(
  parameter int unsigned DEPTH_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               adv_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [DEPTH_W-1:0] remain_o,
  output logic               last_o
);
  logic [DEPTH_W-1:0] cnt_q, depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      depth_q <= '0;
    end else if (load_i) begin
      cnt_q   <= '0;
      depth_q <= depth_i;
    end else if (adv_i) begin
      cnt_q <= cnt_q + DEPTH_W'(1);
    end
  end

  // bytes left after the current one
  assign remain_o = depth_q - DEPTH_W'(1) - cnt_q;
  assign last_o   = (remain_o == '0);
endmodule

// File: rtl/mpt_hdr_track.sv
module mpt_hdr_track
  import mpt_pkg::*;
#(
  parameter int unsigned DEPTH_W = 12,
  parameter int unsigned LEN_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               adv_i,
  input  logic [7:0]         byte_i,
  input  logic [DEPTH_W-1:0] remain_i,
  input  logic               err_i,
  output logic               sop_o,
  output logic               eop_o,
  output logic               bad_o
);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  phase_e           ph_q, ph_d;
  logic [7:0]       hi_q;
  logic [CNT_W-1:0] left_q, left_d;
  logic [LEN_W-1:0] len_w, rem_w;
  logic             len_big, len_over;
  logic             sop_raw, eop_raw, bad_raw;

  assign len_w    = {hi_q, byte_i};
  assign rem_w    = LEN_W'(remain_i);
  assign len_big  = len_w > LEN_W'(MAX_LEN);
  assign len_over = len_w > rem_w;

  always_comb begin
    sop_raw = 1'b0;
    eop_raw = 1'b0;
    bad_raw = 1'b0;
    ph_d    = ph_q;
    left_d  = left_q;
    unique case (ph_q)
      PH_LEN_HI: begin
        sop_raw = 1'b1;
        bad_raw = (remain_i == '0);
        ph_d    = PH_LEN_LO;
      end
      PH_LEN_LO: begin
        if (len_big || len_over) begin
          bad_raw = 1'b1;
          ph_d    = PH_LEN_HI;
        end else if (len_w == '0) begin
          eop_raw = 1'b1;
          ph_d    = PH_LEN_HI;
        end else begin
          left_d = CNT_W'(len_w);
          ph_d   = PH_BODY;
        end
      end
      PH_BODY: begin
        left_d = left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) begin
          eop_raw = 1'b1;
          ph_d    = PH_LEN_HI;
        end
      end
      default: ph_d = PH_LEN_HI;
    endcase
  end

  assign bad_o = adv_i && bad_raw;
  assign sop_o = adv_i && sop_raw && !bad_raw && !err_i;
  assign eop_o = adv_i && eop_raw && !bad_raw && !err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_LEN_HI;
      hi_q   <= '0;
      left_q <= '0;
    end else if (clear_i) begin
      ph_q   <= PH_LEN_HI;
      left_q <= '0;
    end else if (adv_i) begin
      ph_q   <= ph_d;
      left_q <= left_d;
      if (ph_q == PH_LEN_HI) hi_q <= byte_i;
    end
  end
endmodule

// File: rtl/mpt_out_stage.sv
module mpt_out_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic              done_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic              done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      data_o  <= valid_i ? data_i : '0;
      sop_o   <= sop_i;
      eop_o   <= eop_i;
      done_o  <= done_i;
    end
  end
endmodule

// File: rtl/mpt_tx_tracker.sv
module mpt_tx_tracker #(
  parameter int unsigned DEPTH_W = 12,
  parameter int unsigned LEN_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               pkt_start_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  logic               in_valid_i,
  input  logic [7:0]         in_byte_i,
  output logic               out_valid_o,
  output logic [7:0]         out_byte_o,
  output logic               out_sop_o,
  output logic               out_eop_o,
  output logic               buf_done_o,
  output logic               fmt_err_o
);
  logic               active_q, err_q;
  logic               start_ok, accept;
  logic               last, sop, eop, bad;
  logic [DEPTH_W-1:0] remain;

  assign start_ok = pkt_start_i && (depth_i != '0);
  // start cycle drops any byte
  assign accept   = active_q && in_valid_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (start_i) begin
      active_q <= start_ok;
      err_q    <= !start_ok;
    end else begin
      if (accept && last) active_q <= 1'b0;
      if (bad) err_q <= 1'b1;
    end
  end

  mpt_pos_count #(.DEPTH_W(DEPTH_W)) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .adv_i    (accept),
    .depth_i  (depth_i),
    .remain_o (remain),
    .last_o   (last)
  );

  mpt_hdr_track #(.DEPTH_W(DEPTH_W), .LEN_W(LEN_W)) u_hdr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_i),
    .adv_i    (accept),
    .byte_i   (in_byte_i),
    .remain_i (remain),
    .err_i    (err_q),
    .sop_o    (sop),
    .eop_o    (eop),
    .bad_o    (bad)
  );

  mpt_out_stage #(.DATA_W(8)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (accept),
    .data_i  (in_byte_i),
    .sop_i   (sop),
    .eop_i   (eop),
    .done_i  (accept && last),
    .valid_o (out_valid_o),
    .data_o  (out_byte_o),
    .sop_o   (out_sop_o),
    .eop_o   (out_eop_o),
    .done_o  (buf_done_o)
  );

  assign fmt_err_o = err_q;
endmodule

// File: rtl/mpt_tx_tracker_chk.sv
module mpt_tx_tracker_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic pkt_start_i,
  input logic out_valid_o,
  input logic out_sop_o,
  input logic out_eop_o,
  input logic buf_done_o,
  input logic fmt_err_o
);
  p_sop_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> out_valid_o);
  p_eop_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eop_o |-> out_valid_o);
  p_done_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_done_o |-> out_valid_o);
  p_idle_after_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_done_o |=> !out_valid_o);
  p_bad_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !pkt_start_i |=> fmt_err_o);
  p_err_mute_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> !out_sop_o && !out_eop_o);
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o && !start_i |=> fmt_err_o);
  p_start_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !out_valid_o);
endmodule

bind mpt_tx_tracker mpt_tx_tracker_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .pkt_start_i (pkt_start_i),
  .out_valid_o (out_valid_o),
  .out_sop_o   (out_sop_o),
  .out_eop_o   (out_eop_o),
  .buf_done_o  (buf_done_o),
  .fmt_err_o   (fmt_err_o)
);

// File: tb/mpt_tx_tracker_tb_top.sv
module mpt_tx_tracker_tb_top;
  localparam int DEPTH_W = 12;
  localparam int MEM_N = 2304;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, pkt_start_i = 1'b0, in_valid_i = 1'b0;
  logic [DEPTH_W-1:0] depth_i = '0;
  logic [7:0] in_byte_i = '0;
  logic out_valid_o, out_sop_o, out_eop_o, buf_done_o, fmt_err_o;
  logic [7:0] out_byte_o;

  always #4 clk = ~clk;

  mpt_tx_tracker #(.DEPTH_W(DEPTH_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pkt_start_i(pkt_start_i),
    .depth_i(depth_i), .in_valid_i(in_valid_i), .in_byte_i(in_byte_i),
    .out_valid_o(out_valid_o), .out_byte_o(out_byte_o), .out_sop_o(out_sop_o),
    .out_eop_o(out_eop_o), .buf_done_o(buf_done_o), .fmt_err_o(fmt_err_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] mem [MEM_N];
  bit e_sop [MEM_N], e_eop [MEM_N], e_err [MEM_N];
  logic [7:0] r_byte [MEM_N];
  bit r_sop [MEM_N], r_eop [MEM_N], r_done [MEM_N], r_err [MEM_N];
  int rec_n = 0;
  bit e_final_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (out_valid_o && rec_n < MEM_N) begin
      r_byte[rec_n] = out_byte_o; r_sop[rec_n] = out_sop_o;
      r_eop[rec_n] = out_eop_o; r_done[rec_n] = buf_done_o;
      r_err[rec_n] = fmt_err_o;
      rec_n++;
    end
  end

  // model of the requirements: tags per byte index
  function automatic void model(input int depth);
    int ph = 0, left = 0, len;
    bit err = 0, bad, sop, eop;
    logic [7:0] hi = 0;
    for (int i = 0; i < depth; i++) begin
      bad = 0; sop = 0; eop = 0;
      if (ph == 0) begin
        sop = 1; hi = mem[i]; ph = 1;
        if (i == depth - 1) bad = 1;                // R8 prefix at last byte
      end else if (ph == 1) begin
        len = {hi, mem[i]};
        if (len > 2046 || i + len > depth - 1) begin bad = 1; ph = 0; end
        else if (len == 0) begin eop = 1; ph = 0; end
        else begin left = len; ph = 2; end
      end else begin
        left--;
        if (left == 0) begin eop = 1; ph = 0; end
      end
      if (bad) err = 1;
      e_sop[i] = sop && !err;
      e_eop[i] = eop && !err;
      e_err[i] = err;
    end
    e_final_err = err;
  endfunction

  function automatic int put_pkt(input int at, input int len);
    mem[at] = len[15:8]; mem[at+1] = len[7:0];
    for (int k = 0; k < len; k++) mem[at+2+k] = 8'($urandom);
    return at + 2 + len;
  endfunction

  task automatic run_buf(input bit ps, input int depth, input int nsend, input string tag);
    int exp_n, bad_b, bad_s, bad_e, bad_d, bad_r, first;
    for (int i = depth; i < MEM_N; i++) mem[i] = 8'($urandom);
    model(depth);
    rec_n = 0;
    @(negedge clk);
    start_i = 1; pkt_start_i = ps; depth_i = DEPTH_W'(depth);
    in_valid_i = 1; in_byte_i = 8'hEE;               // R10 dropped byte
    @(negedge clk);
    start_i = 0; in_valid_i = 0;
    for (int i = 0; i < nsend; i++) begin
      while ($urandom_range(0, 3) == 0) @(negedge clk);
      in_valid_i = 1; in_byte_i = mem[i];
      @(negedge clk);
      in_valid_i = 0;
    end
    repeat (3) @(negedge clk);
    exp_n = (ps && depth != 0) ? ((nsend < depth) ? nsend : depth) : 0;
    chk(rec_n == exp_n, "R2/R5/R10", {tag, " byte count"}, rec_n, exp_n);
    bad_b = 0; bad_s = 0; bad_e = 0; bad_d = 0; bad_r = 0; first = -1;
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      if (r_byte[i] != mem[i]) bad_b++;
      if (r_sop[i] != e_sop[i]) bad_s++;
      if (r_eop[i] != e_eop[i]) bad_e++;
      if (r_done[i] != (i == depth - 1)) bad_d++;
      if (r_err[i] != e_err[i]) begin bad_r++; if (first < 0) first = i; end
    end
    chk(bad_b == 0, "R2", {tag, " byte mismatches"}, bad_b, 0);
    chk(bad_s == 0, "R3", {tag, " sop mismatches"}, bad_s, 0);
    chk(bad_e == 0, "R4", {tag, " eop mismatches"}, bad_e, 0);
    chk(bad_d == 0, "R5", {tag, " done mismatches"}, bad_d, 0);
    chk(bad_r == 0, "R7/R8", {tag, " err mismatches (first index)"}, first, -1);
    if (ps && depth != 0 && nsend >= depth)
      chk(fmt_err_o == e_final_err, "R9", {tag, " final err"}, fmt_err_o, e_final_err);
    if (!(ps && depth != 0))
      chk(fmt_err_o == 1'b1, "R6", {tag, " bad start err"}, fmt_err_o, 1);
  endtask

  initial begin
    int at, d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({out_valid_o, out_byte_o, out_sop_o, out_eop_o, buf_done_o, fmt_err_o} == '0,
        "R1", "reset outputs", int'(out_valid_o), 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    at = put_pkt(0, 0); at = put_pkt(at, 5); at = put_pkt(at, 1);
    run_buf(1, at, at, "R3 directed lens 0/5/1");

    for (int b = 0; b < 20; b++) begin
      at = 0;
      for (int p = 0; p < $urandom_range(1, 6); p++) at = put_pkt(at, $urandom_range(0, 40));
      run_buf(1, at, at + $urandom_range(0, 4), "R4 random");
    end

    at = put_pkt(0, 2046);
    run_buf(1, at, at, "R7 max len 2046");
    void'(put_pkt(0, 2040)); mem[0] = 8'h07; mem[1] = 8'hFF;      // 2047
    run_buf(1, 2050, 2050, "R7 len 2047");

    void'(put_pkt(0, 10));
    run_buf(1, 8, 8, "R8 overrun");
    at = put_pkt(0, 3);
    run_buf(1, at + 1, at + 1, "R8 prefix at last byte");

    void'(put_pkt(0, 4));
    run_buf(0, 6, 6, "R6 no packet-start");
    run_buf(1, 0, 4, "R6 zero depth");

    at = put_pkt(0, 9); d = put_pkt(at, 2);
    run_buf(1, d, 4, "R10 partial");
    run_buf(1, d, d, "R9/R10 restart clears err");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule